// File: doc/BRIEF.md
# SIMD Element Grid

This block is a two-dimensional grid of small processing elements that all obey one controller. In every clock cycle the controller presents a single instruction to all elements at once, along with one shared scalar value. The instruction fields are an opcode, a neighbour direction, three register selectors, a scalar-select bit and an immediate. The immediate is also the private-memory address for loads and stores. Each element has a small register file, a private memory and an activity flag. It carries out the instruction on its own data only while its flag is set.

The flag is computed inside each element from its own registers, which gives the array conditional execution. A shift instruction moves a register value one step across a toroidal mesh in any of eight compass directions. A reduction path reports to the controller how many elements are active, and whether any are. A gather bus shows the selected register of every element, so the controller can collect per-element results.

Top module: `simd_grid`

## Requirements
- R1: After reset, every activity flag is 1 and every register and memory word in every element is 0. `status_any` is 1 and `status_count` equals ROWS*COLS.
- R2: Opcodes 1 (ADD), 2 (SUB), 3 (AND), 4 (OR) and 5 (XOR) write register `rd_in` of each active element with reg[`ra_in`] op B, modulo 2^DW. B is `scalar_in` when `scalar_sel_in` is 1, and reg[`rb_in`] otherwise.
- R3: Opcode 6 writes `imm_in` into register `rd_in` of every active element.
- R4: Opcode 7 loads the private word at address `imm_in[AW-1:0]` (AW = log2 MEM_DEPTH) into `rd_in`. Opcode 8 stores reg[`ra_in`] at that address. The address is the same for every element.
- R5: An element whose flag is 0 keeps its registers, memory and flag for every opcode except 12. Opcodes 0, 14 and 15 change nothing in any element.
- R6: Opcode 10 sets the flag of each active element to (reg[`ra_in`] < B), compared unsigned, with B as in R2. Opcode 11 sets it to (reg[`ra_in`] == 0).
- R7: Opcode 12 sets every flag to 1, whatever its current value.
- R8: Opcode 9 makes data travel one step in direction `dir_in`. The codes are 0 N (row-1), 1 NE, 2 E (col+1), 3 SE, 4 S, 5 SW, 6 W and 7 NW. Row 0 is the top row. Each active element writes into `rd_in` the reg[`ra_in`] of the element one step against that direction. Row and column indices wrap around, and the flag of the sending element has no effect.
- R9: The outputs settle at the rising edge that executes an instruction, that is, one cycle after it is presented. `status_count` then equals the number of flags set by that instruction, and `status_any` is 1 exactly when that count is nonzero.
- R10: `peek_data[e*DW +: DW]`, with e = row*COLS+col, shows reg[`ra_in`] of element e combinationally.
- R11: Opcode 13 writes the element's own index e into `rd_in` of every active element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 4 | Broadcast opcode |
| dir_in | input | 3 | Neighbour direction for shifts |
| rd_in | input | log2 NREG | Destination register |
| ra_in | input | log2 NREG | First source register; also the gather selector |
| rb_in | input | log2 NREG | Second source register |
| scalar_sel_in | input | 1 | Use `scalar_in` as operand B |
| imm_in | input | DW | Immediate value and shared memory address |
| scalar_in | input | DW | Controller scalar operand |
| peek_data | output | ROWS*COLS*DW | Gather of reg[`ra_in`] from every element |
| status_any | output | 1 | OR of all activity flags, registered |
| status_count | output | log2(ROWS*COLS+1) | Number of active elements, registered |

## Verification
The embedded properties assume the controller holds every instruction field stable for a whole cycle and changes fields only between edges. They also assume the register and memory selectors stay within NREG and MEM_DEPTH, which the power-of-two parameter checks guarantee. The stimulus drives each instruction at a falling edge and returns to opcode 0 just after the rising edge that executes it. It reads the gather bus and the status only while opcode 0 is applied, so an observation never alters state. Per-element diversity comes from opcode 13. After that, masks are built from the elements' own data, so every sweep runs with both active and inactive elements present.

// File: rtl/simd_grid_pkg.sv
package simd_grid_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_ADD    = 4'd1,
      OP_SUB    = 4'd2,
      OP_AND    = 4'd3,
      OP_OR     = 4'd4,
      OP_XOR    = 4'd5,
      OP_MOVI   = 4'd6,
      OP_LOAD   = 4'd7,
      OP_STORE  = 4'd8,
      OP_SHIFT  = 4'd9,
      OP_SLT    = 4'd10,
      OP_SEZ    = 4'd11,
      OP_SETALL = 4'd12,
      OP_IDX    = 4'd13
   } pe_op_e;

   // row step of a direction code: 0 N,1 NE,2 E,3 SE,4 S,5 SW,6 W,7 NW
   function automatic int dir_drow(input int d);
      if (d == 0 || d == 1 || d == 7) return -1;
      if (d == 3 || d == 4 || d == 5) return 1;
      return 0;
   endfunction

   // column step of a direction code
   function automatic int dir_dcol(input int d);
      if (d >= 1 && d <= 3) return 1;
      if (d >= 5 && d <= 7) return -1;
      return 0;
   endfunction

endpackage

// File: rtl/simd_pe.sv
module simd_pe
   import simd_grid_pkg::*;
#(
   parameter int DW        = 8,
   parameter int NREG      = 4,
   parameter int MEM_DEPTH = 8,
   parameter int ID        = 0,
   localparam int RW = $clog2(NREG),
   localparam int AW = $clog2(MEM_DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  pe_op_e              op,
   input  logic [2:0]          dir,
   input  logic [RW-1:0]       rd,
   input  logic [RW-1:0]       ra,
   input  logic [RW-1:0]       rb,
   input  logic                scalar_sel,
   input  logic [DW-1:0]       imm,
   input  logic [DW-1:0]       scalar,
   input  logic [7:0][DW-1:0]  nbr_in,
   output logic [DW-1:0]       src_q,
   output logic                flag_q,
   output logic                flag_d
);

   logic [NREG-1:0][DW-1:0]      regs_q;
   logic [MEM_DEPTH-1:0][DW-1:0] mem_q;
   logic [DW-1:0] opa, opb, wr_val;
   logic [AW-1:0] addr;
   logic          wr_en, st_en;

   assign opa   = regs_q[ra];
   assign opb   = scalar_sel ? scalar : regs_q[rb];
   assign addr  = imm[AW-1:0];
   assign src_q = opa;

   always_comb begin
      wr_en  = 1'b0;
      st_en  = 1'b0;
      wr_val = '0;
      flag_d = flag_q;
      if (op == OP_SETALL) begin
         flag_d = 1'b1;
      end else if (flag_q) begin
         case (op)
            OP_ADD:   begin wr_en = 1'b1; wr_val = opa + opb; end
            OP_SUB:   begin wr_en = 1'b1; wr_val = opa - opb; end
            OP_AND:   begin wr_en = 1'b1; wr_val = opa & opb; end
            OP_OR:    begin wr_en = 1'b1; wr_val = opa | opb; end
            OP_XOR:   begin wr_en = 1'b1; wr_val = opa ^ opb; end
            OP_MOVI:  begin wr_en = 1'b1; wr_val = imm; end
            OP_LOAD:  begin wr_en = 1'b1; wr_val = mem_q[addr]; end
            OP_STORE: st_en = 1'b1;
            OP_SHIFT: begin wr_en = 1'b1; wr_val = nbr_in[dir]; end
            OP_SLT:   flag_d = (opa < opb);
            OP_SEZ:   flag_d = (opa == '0);
            OP_IDX:   begin wr_en = 1'b1; wr_val = DW'(ID); end
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
         mem_q  <= '0;
         flag_q <= 1'b1;
      end else begin
         if (wr_en) regs_q[rd] <= wr_val;
         if (st_en) mem_q[addr] <= opa;
         flag_q <= flag_d;
      end
   end

   // R5
   inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && op != OP_SETALL) |=> ($stable(regs_q) && $stable(mem_q) && !flag_q));

   // R7
   setall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SETALL) |=> flag_q);

   // R6
   zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && op == OP_SEZ) |=> (flag_q == ($past(opa) == '0)));

   // R5
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NOP) |=> ($stable(regs_q) && $stable(mem_q) && $stable(flag_q)));

endmodule

// File: rtl/simd_status_reduce.sv
module simd_status_reduce #(
   parameter int N = 16,
   localparam int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  flags_d,
   output logic          any_q,
   output logic [CW-1:0] cnt_q
);

   logic [CW-1:0] cnt_d;

   always_comb begin
      cnt_d = '0;
      for (int i = 0; i < N; i++) cnt_d = cnt_d + CW'(flags_d[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         any_q <= 1'b1;
         cnt_q <= CW'(N);
      end else begin
         any_q <= |flags_d;
         cnt_q <= cnt_d;
      end
   end

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(N));

   // R9
   any_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_q == (cnt_q != '0));

endmodule

// File: rtl/simd_grid.sv
module simd_grid
   import simd_grid_pkg::*;
#(
   parameter int ROWS      = 4,
   parameter int COLS      = 4,
   parameter int DW        = 8,
   parameter int NREG      = 4,
   parameter int MEM_DEPTH = 8,
   localparam int NPE = ROWS * COLS,
   localparam int RW  = $clog2(NREG),
   localparam int CW  = $clog2(NPE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_in,
   input  logic [2:0]        dir_in,
   input  logic [RW-1:0]     rd_in,
   input  logic [RW-1:0]     ra_in,
   input  logic [RW-1:0]     rb_in,
   input  logic              scalar_sel_in,
   input  logic [DW-1:0]     imm_in,
   input  logic [DW-1:0]     scalar_in,
   output logic [NPE*DW-1:0] peek_data,
   output logic              status_any,
   output logic [CW-1:0]     status_count
);

   if (ROWS < 2 || COLS < 2) begin : g_bad_shape
      $error("grid needs at least two rows and two columns");
   end
   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_regs
      $error("NREG must be a power of two, at least 2");
   end
   if (MEM_DEPTH < 2 || (1 << $clog2(MEM_DEPTH)) != MEM_DEPTH || MEM_DEPTH > (1 << DW)) begin : g_bad_mem
      $error("MEM_DEPTH must be a power of two addressable by the immediate");
   end
   if (NPE > (1 << DW)) begin : g_bad_id
      $error("element index must fit in a data word");
   end

   pe_op_e        op;
   logic [DW-1:0] src     [NPE];
   logic          flag_q  [NPE];
   logic          flag_dn [NPE];
   logic [NPE-1:0] flag_vec, flag_next;

   assign op = pe_op_e'(op_in);

   always_comb begin
      for (int i = 0; i < NPE; i++) begin
         flag_vec[i]  = flag_q[i];
         flag_next[i] = flag_dn[i];
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int E = r * COLS + c;
         logic [7:0][DW-1:0] nbr;

         for (genvar d = 0; d < 8; d++) begin : g_dir
            localparam int SR = (r - dir_drow(d) + ROWS) % ROWS;
            localparam int SC = (c - dir_dcol(d) + COLS) % COLS;
            assign nbr[d] = src[SR * COLS + SC];
         end

         simd_pe #(
            .DW(DW), .NREG(NREG), .MEM_DEPTH(MEM_DEPTH), .ID(E)
         ) i_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (op),
            .dir       (dir_in),
            .rd        (rd_in),
            .ra        (ra_in),
            .rb        (rb_in),
            .scalar_sel(scalar_sel_in),
            .imm       (imm_in),
            .scalar    (scalar_in),
            .nbr_in    (nbr),
            .src_q     (src[E]),
            .flag_q    (flag_q[E]),
            .flag_d    (flag_dn[E])
         );

         assign peek_data[E*DW +: DW] = src[E];
      end
   end

   simd_status_reduce #(.N(NPE)) i_reduce (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags_d(flag_next),
      .any_q  (status_any),
      .cnt_q  (status_count)
   );

   // R9
   count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_count == CW'($countones(flag_vec)));

   // R7
   setall_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SETALL) |=> (status_count == CW'(NPE)));

endmodule

// File: tb/test_simd_grid.sv
`timescale 1ns/1ps
module test_simd_grid;

   localparam int NE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_in = '0;
   logic [2:0]  dir_in = '0;
   logic [1:0]  rd_in = '0, ra_in = '0, rb_in = '0;
   logic        scalar_sel_in = 1'b0;
   logic [7:0]  imm_in = '0, scalar_in = '0;
   logic [127:0] peek_data;
   logic        status_any;
   logic [4:0]  status_count;

   int total = 0;
   int fails = 0;
   int cyc = 0;

   logic [7:0] m_reg [NE][4];
   logic [7:0] m_mem [NE][8];
   bit         m_flag [NE];

   int DR [8] = '{-1, -1, 0, 1, 1, 1, 0, -1};
   int DC [8] = '{0, 1, 1, 1, 0, -1, -1, -1};

   simd_grid i_simd_grid (
      .clk(clk), .rst_n(rst_n), .op_in(op_in), .dir_in(dir_in),
      .rd_in(rd_in), .ra_in(ra_in), .rb_in(rb_in),
      .scalar_sel_in(scalar_sel_in), .imm_in(imm_in), .scalar_in(scalar_in),
      .peek_data(peek_data), .status_any(status_any), .status_count(status_count)
   );

   always #4 clk = ~clk;

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         total++;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 50000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] alu(input logic [3:0] o, input logic [7:0] a, b);
      case (o)
         4'd1: return a + b;
         4'd2: return a - b;
         4'd3: return a & b;
         4'd4: return a | b;
         default: return a ^ b;
      endcase
   endfunction

   task automatic exec(input logic [3:0] o, input logic [2:0] d,
                       input logic [1:0] rdx, input logic [1:0] rax, input logic [1:0] rbx,
                       input logic sel, input logic [7:0] im, input logic [7:0] sc);
      logic [7:0] nr [NE][4];
      logic [7:0] nm [NE][8];
      bit         nf [NE];
      @(negedge clk);
      op_in = o; dir_in = d; rd_in = rdx; ra_in = rax; rb_in = rbx;
      scalar_sel_in = sel; imm_in = im; scalar_in = sc;
      nr = m_reg; nm = m_mem; nf = m_flag;
      for (int e = 0; e < NE; e++) begin
         int r, c, se;
         logic [7:0] a, b;
         r = e / 4; c = e % 4;
         se = ((r - DR[d] + 4) % 4) * 4 + ((c - DC[d] + 4) % 4);
         a = m_reg[e][rax];
         b = sel ? sc : m_reg[e][rbx];
         if (o == 4'd12) nf[e] = 1'b1;
         else if (m_flag[e]) begin
            case (o)
               4'd1, 4'd2, 4'd3, 4'd4, 4'd5: nr[e][rdx] = alu(o, a, b);
               4'd6:  nr[e][rdx] = im;
               4'd7:  nr[e][rdx] = m_mem[e][im[2:0]];
               4'd8:  nm[e][im[2:0]] = a;
               4'd9:  nr[e][rdx] = m_reg[se][rax];
               4'd10: nf[e] = (a < b);
               4'd11: nf[e] = (a == 8'd0);
               4'd13: nr[e][rdx] = 8'(e);
               default: ;
            endcase
         end
      end
      @(posedge clk);
      m_reg = nr; m_mem = nm; m_flag = nf;
      #1;
      op_in = 4'd0;
   endtask

   task automatic check_state(input string tag);
      int cnt;
      @(negedge clk);
      op_in = 4'd0;
      for (int k = 0; k < 4; k++) begin
         int bad, act, exp;
         ra_in = 2'(k);
         #0.5;
         bad = -1; act = 0; exp = 0;
         for (int e = 0; e < NE; e++) begin
            if (bad < 0 && peek_data[e*8 +: 8] !== m_reg[e][k]) begin
               bad = e; act = int'(peek_data[e*8 +: 8]); exp = int'(m_reg[e][k]);
            end
         end
         chk(bad < 0, tag, $sformatf("reg%0d element %0d", k, bad), act, exp);
      end
      cnt = 0;
      for (int e = 0; e < NE; e++) cnt += int'(m_flag[e]);
      chk(status_count == 5'(cnt), tag, "status_count (R9)", int'(status_count), cnt);
      chk(status_any == (cnt != 0), tag, "status_any (R9)", int'(status_any), int'(cnt != 0));
      ra_in = 2'd0;
   endtask

   initial begin
      for (int e = 0; e < NE; e++) begin
         m_flag[e] = 1'b1;
         for (int k = 0; k < 4; k++) m_reg[e][k] = '0;
         for (int k = 0; k < 8; k++) m_mem[e][k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of registers, flags and status
      check_state("R1");
      // R1 / R4: memory is zero after reset
      for (int a = 0; a < 8; a++) exec(4'd7, 0, 3, 0, 0, 0, 8'(a), 0);
      check_state("R1");

      // R11: own index
      exec(4'd13, 0, 0, 0, 0, 0, 0, 0);
      check_state("R11");
      // R3: immediate move
      exec(4'd6, 0, 1, 0, 0, 0, 8'h3C, 0);
      check_state("R3");

      // R2: ALU sweep, register and scalar operand B
      for (int o = 1; o <= 5; o++)
         for (int s = 0; s < 2; s++)
            for (int v = 0; v < 3; v++) begin
               logic [7:0] sc;
               sc = (v == 0) ? 8'h05 : (v == 1) ? 8'hF0 : 8'hFF;
               exec(4'(o), 0, 2, 0, 1, s[0], 0, sc);
               check_state("R2");
            end

      // R6: flag from unsigned compare with scalar
      exec(4'd10, 0, 0, 0, 0, 1, 0, 8'd8);
      check_state("R6");
      // R5: masked elements keep registers
      exec(4'd6, 0, 1, 0, 0, 0, 8'hAA, 0);
      check_state("R5");
      exec(4'd1, 0, 2, 0, 0, 1, 0, 8'h11);
      check_state("R5");
      // R4: masked store, then everyone reloads
      exec(4'd8, 0, 0, 0, 0, 0, 8'd3, 0);
      // R7: re-enable all
      exec(4'd12, 0, 0, 0, 0, 0, 0, 0);
      check_state("R7");
      exec(4'd7, 0, 3, 0, 0, 0, 8'd3, 0);
      check_state("R4");
      exec(4'd8, 0, 0, 1, 0, 0, 8'hF6, 0);
      exec(4'd7, 0, 2, 0, 0, 0, 8'd6, 0);
      check_state("R4");

      // R6: zero test on loaded data, then register-operand compare
      exec(4'd11, 0, 0, 3, 0, 0, 0, 0);
      check_state("R6");

      // R8: shifts in all directions under a partial mask
      for (int d = 0; d < 8; d++) begin
         exec(4'd9, 3'(d), 2, 0, 0, 0, 0, 0);
         check_state("R8");
      end
      exec(4'd12, 0, 0, 0, 0, 0, 0, 0);
      exec(4'd1, 0, 3, 0, 0, 1, 0, 8'h40);
      for (int d = 0; d < 8; d++) begin
         exec(4'd9, 3'(d), 1, 3, 0, 0, 0, 0);
         check_state("R8");
      end
      exec(4'd10, 0, 0, 1, 0, 0, 0, 0);
      check_state("R6");

      // R9 / R5: nobody active, nothing may change
      exec(4'd12, 0, 0, 0, 0, 0, 0, 0);
      exec(4'd10, 0, 0, 0, 0, 1, 0, 8'd0);
      check_state("R9");
      exec(4'd6, 0, 0, 0, 0, 0, 8'h77, 0);
      exec(4'd8, 0, 0, 1, 0, 0, 8'd6, 0);
      exec(4'd13, 0, 2, 0, 0, 0, 0, 0);
      exec(4'd9, 3'd2, 3, 0, 0, 0, 0, 0);
      exec(4'd11, 0, 0, 0, 0, 0, 0, 0);
      exec(4'd14, 0, 0, 0, 0, 0, 0, 0);
      check_state("R5");
      exec(4'd12, 0, 0, 0, 0, 0, 0, 0);
      exec(4'd7, 0, 3, 0, 0, 0, 8'd6, 0);
      check_state("R5");
      // R10: gather bus exercised through every check_state above
      check_state("R10");

      summary();
      $finish;
   end

endmodule